// File: doc/BRIEF.md
# C/A Gold Code Replica with Dither

This block generates the 1023-chip Gold code of one of 32 selectable satellites. It steps the code each time the code clock modulator sends a chip enable, and it flags the start of every code period with a one-cycle epoch pulse. Around the generator it keeps the phase state of a replica satellite clock. A chip phase counter runs from 0 to 1022 within each code period. An epoch counter divides the epochs by 20 to form a 50 Hz data clock. Both counters can be frozen into latches by a snapshot strobe, so the replica time can be read at one instant.

A resynchronisation request realigns the divide-by-20 so that it matches the received data bit edges. It is served by a two-state controller. SYNC_FREE is the normal state: a request moves it to SYNC_ARMED. In SYNC_ARMED, the first epoch restarts the data divider at zero and returns the controller to SYNC_FREE.

The block also drives a dithered code output. A dither clock runs at one sixth of the epoch rate. While it is high, the dithered output carries a copy of the prompt code delayed by a programmable number of reference cycles. While it is low, the dithered output carries the prompt code.

Top module: `gold_replica`

## Requirements
- R1: Register stages are numbered 1 to 10, and every shift moves stage k into stage k+1. G1 feeds stage 1 with stage 3 XOR stage 10. G2 feeds stage 1 with the XOR of stages 2, 3, 6, 8, 9 and 10. `code_prompt` is G1 stage 10 XOR two G2 stages chosen by `sv_sel`. Each value of `sv_sel` (0 to 31) selects satellite `sv_sel`+1. The G2 stage pairs, listed by satellite from 1 to 32, are: (2,6) (3,7) (4,8) (5,9) (1,9) (2,10) (1,8) (2,9) (3,10) (2,3) (3,4) (5,6) (6,7) (7,8) (8,9) (9,10) (1,4) (2,5) (3,6) (4,7) (5,8) (6,9) (1,3) (4,6) (5,7) (6,8) (7,9) (8,10) (1,6) (2,7) (3,8) (4,9). For `sv_sel`=0, the first ten chips after reset are 1,1,0,0,1,0,0,0,0,0.
- R2: While `rst_n` is low, the following hold:
  - both registers are all ones, so `code_prompt` is 1;
  - `epoch` is 0;
  - `data_clk` and `dither_clk` are 1;
  - both phase latches read 0;
  - the delay history reads 0.
- R3: Both registers shift only on a clock edge where `chip_en` is 1. Otherwise they hold, and `code_prompt` does not change.
- R4: Call the enabled edge that returns both registers to all ones a wrap edge. Each wrap edge occurs exactly 1023 enables after the previous one, or after reset. The chip counter starts at 0 and increments on each enable. On a wrap edge it clears to 0, so it never exceeds 1022. `epoch` is 1 for exactly the one cycle after each wrap edge, and the chip counter is 0 during that cycle.
- R5: On an edge where `snap` is 1, `chip_phase` takes the chip count and `data_phase` takes the epoch count, both as they were before that edge. Otherwise both latches hold.
- R6: The epoch count steps on every wrap edge, from 0 through 19 and then back to 0. `data_clk` is 1 while the count is 0 to 9 and 0 while it is 10 to 19.
- R7: A `resync_req` pulse arms a realignment. The first wrap edge in a later cycle sets the epoch count to 0 instead of stepping it, and disarms. Further requests while armed change nothing. A request on the edge where the realignment takes place is absorbed.
- R8: A dither count steps 0 through 5 on wrap edges and then wraps to 0. `dither_clk` is 1 for counts 0 to 2 and 0 for counts 3 to 5, so it changes only when `epoch` rises.
- R9: The delayed copy equals the `code_prompt` value of D reference cycles earlier. D is `dly_sel`, with 0 raised to 1 and values above 19 lowered to 19.
- R10: `code_dither` carries the delayed copy while `dither_clk` is 1 and carries `code_prompt` while `dither_clk` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock (20 code-clock periods per chip) |
| rst_n | input | 1 | Asynchronous active-low reset |
| chip_en | input | 1 | Chip advance enable from the code clock modulator |
| sv_sel | input | 5 | Satellite select, 0 to 31 |
| dly_sel | input | 5 | Delay of the dither copy in reference cycles |
| snap | input | 1 | Snapshot strobe for the phase latches |
| resync_req | input | 1 | Request to realign the data divider at the next epoch |
| code_prompt | output | 1 | Prompt Gold code chip |
| code_dither | output | 1 | Prompt/delayed code switched by the dither clock |
| epoch | output | 1 | One-cycle pulse at the start of each code period |
| data_clk | output | 1 | 50 Hz data clock derived from the epochs |
| dither_clk | output | 1 | Dither clock at one sixth of the epoch rate |
| chip_phase | output | 10 | Latched chip phase |
| data_phase | output | 5 | Latched epoch count within the data bit |

## Verification
The hardest case to reach from the ports is a realignment request, or a snapshot, that lands on exactly the edge where the code wraps. Epochs are a thousand enables apart, so random stimulus almost never hits that edge. The bench therefore tracks the chip index in its own model and drives enables until the index reaches 1022. It then issues the request or strobe together with the wrapping enable. Long random runs with irregular enables, occasional satellite and delay changes, and rare requests then sweep the divider through more than 20 epochs, so that its wrap and the armed-but-idle state are both covered.

// File: rtl/gr_pkg.sv
package gr_pkg;
    localparam int REG_W      = 10;
    localparam int SEL_W      = 5;
    localparam int CHIPS      = 1023;
    localparam int CHIP_W     = $clog2(CHIPS);
    localparam int DATA_DIV   = 20;
    localparam int DATA_W     = $clog2(DATA_DIV);
    localparam int DITHER_DIV = 6;
    localparam int DITHER_W   = $clog2(DITHER_DIV);
    localparam int DLY_MAX    = 19;
    localparam int IDX_W      = $clog2(REG_W);

    localparam logic [REG_W-1:0] G1_FB_MASK = 10'b10_0000_0100;
    localparam logic [REG_W-1:0] G2_FB_MASK = 10'b11_1010_0110;

    typedef enum logic {SYNC_FREE, SYNC_ARMED} sync_st_t;

    typedef struct packed {
        logic [IDX_W-1:0] a;
        logic [IDX_W-1:0] b;
    } tap_pair_t;

    function automatic tap_pair_t mk(input int s1, input int s2);
        tap_pair_t t;
        t.a = IDX_W'(s1 - 1);
        t.b = IDX_W'(s2 - 1);
        return t;
    endfunction

    function automatic tap_pair_t g2_taps(input logic [SEL_W-1:0] sv);
        tap_pair_t t;
        unique case (sv)
            5'd0:  t = mk(2, 6);   5'd1:  t = mk(3, 7);
            5'd2:  t = mk(4, 8);   5'd3:  t = mk(5, 9);
            5'd4:  t = mk(1, 9);   5'd5:  t = mk(2, 10);
            5'd6:  t = mk(1, 8);   5'd7:  t = mk(2, 9);
            5'd8:  t = mk(3, 10);  5'd9:  t = mk(2, 3);
            5'd10: t = mk(3, 4);   5'd11: t = mk(5, 6);
            5'd12: t = mk(6, 7);   5'd13: t = mk(7, 8);
            5'd14: t = mk(8, 9);   5'd15: t = mk(9, 10);
            5'd16: t = mk(1, 4);   5'd17: t = mk(2, 5);
            5'd18: t = mk(3, 6);   5'd19: t = mk(4, 7);
            5'd20: t = mk(5, 8);   5'd21: t = mk(6, 9);
            5'd22: t = mk(1, 3);   5'd23: t = mk(4, 6);
            5'd24: t = mk(5, 7);   5'd25: t = mk(6, 8);
            5'd26: t = mk(7, 9);   5'd27: t = mk(8, 10);
            5'd28: t = mk(1, 6);   5'd29: t = mk(2, 7);
            5'd30: t = mk(3, 8);   default: t = mk(4, 9);
        endcase
        return t;
    endfunction
endpackage

// File: rtl/gr_lfsr.sv
module gr_lfsr #(
    parameter int               W    = 10,
    parameter logic [W-1:0]     MASK = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         adv,
    output logic [W-1:0] q,
    output logic         nxt_ones
);
    logic [W-1:0] nxt;

    always_comb begin
        nxt      = {q[W-2:0], ^(q & MASK)};
        nxt_ones = &nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   q <= '1;
        else if (adv) q <= nxt;
    end

    // R3: register holds without an advance
    a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |=> $stable(q));
endmodule

// File: rtl/phase_track.sv
module phase_track
    import gr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chip_en,
    input  logic              wrap,
    input  logic              snap,
    input  logic              resync_req,
    output logic              epoch,
    output logic              data_clk,
    output logic              dither_clk,
    output logic [CHIP_W-1:0] chip_phase,
    output logic [DATA_W-1:0] data_phase
);
    sync_st_t            st_q, st_d;
    logic                realign;
    logic [CHIP_W-1:0]   chip_cnt;
    logic [DATA_W-1:0]   data_cnt;
    logic [DITHER_W-1:0] dith_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= SYNC_FREE;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d    = st_q;
        realign = 1'b0;
        unique case (st_q)
            SYNC_FREE:  if (resync_req) st_d = SYNC_ARMED;
            SYNC_ARMED: if (wrap) begin
                st_d    = SYNC_FREE;
                realign = 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chip_cnt   <= '0;
            data_cnt   <= '0;
            dith_cnt   <= '0;
            epoch      <= 1'b0;
            chip_phase <= '0;
            data_phase <= '0;
        end else begin
            epoch <= wrap;
            if (snap) begin
                chip_phase <= chip_cnt;
                data_phase <= data_cnt;
            end
            if (wrap)         chip_cnt <= '0;
            else if (chip_en) chip_cnt <= chip_cnt + 1'b1;
            if (wrap) begin
                if (realign)                             data_cnt <= '0;
                else if (data_cnt == DATA_W'(DATA_DIV-1)) data_cnt <= '0;
                else                                     data_cnt <= data_cnt + 1'b1;
                if (dith_cnt == DITHER_W'(DITHER_DIV-1)) dith_cnt <= '0;
                else                                     dith_cnt <= dith_cnt + 1'b1;
            end
        end
    end

    always_comb begin
        data_clk   = data_cnt < DATA_W'(DATA_DIV/2);
        dither_clk = dith_cnt < DITHER_W'(DITHER_DIV/2);
    end

    a_r4_chip_range: assert property (@(posedge clk) disable iff (!rst_n)
        chip_cnt <= CHIP_W'(CHIPS-1));
    a_r4_epoch_zero: assert property (@(posedge clk) disable iff (!rst_n)
        epoch |-> chip_cnt == '0);
    a_r6_data_range: assert property (@(posedge clk) disable iff (!rst_n)
        data_cnt <= DATA_W'(DATA_DIV-1));
    a_r7_realign: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == SYNC_ARMED && wrap) |=> data_cnt == '0);
    a_r8_dither_edge: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(dither_clk) |-> epoch);
endmodule

// File: rtl/dither_mux.sv
module dither_mux
    import gr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             prompt,
    input  logic             dither_clk,
    input  logic [SEL_W-1:0] dly_sel,
    output logic             code_dither
);
    localparam int DEPTH = DLY_MAX;

    logic [DEPTH-1:0] hist;
    logic [SEL_W-1:0] dly_eff;
    logic             delayed;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hist <= '0;
        else        hist <= {hist[DEPTH-2:0], prompt};
    end

    always_comb begin
        if (dly_sel == '0)                      dly_eff = SEL_W'(1);
        else if (dly_sel > SEL_W'(DEPTH))       dly_eff = SEL_W'(DEPTH);
        else                                    dly_eff = dly_sel;
        delayed     = hist[dly_eff - 1'b1];
        code_dither = dither_clk ? delayed : prompt;
    end

    a_r9_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (dly_eff == SEL_W'(1) && $past(rst_n)) |-> delayed == $past(prompt));
    a_r9_clamped: assert property (@(posedge clk) disable iff (!rst_n)
        dly_eff >= SEL_W'(1) && dly_eff <= SEL_W'(DEPTH));
endmodule

// File: rtl/gold_replica.sv
module gold_replica
    import gr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chip_en,
    input  logic [SEL_W-1:0]  sv_sel,
    input  logic [SEL_W-1:0]  dly_sel,
    input  logic              snap,
    input  logic              resync_req,
    output logic              code_prompt,
    output logic              code_dither,
    output logic              epoch,
    output logic              data_clk,
    output logic              dither_clk,
    output logic [CHIP_W-1:0] chip_phase,
    output logic [DATA_W-1:0] data_phase
);
    localparam logic [REG_W-1:0] MASKS [2] = '{G1_FB_MASK, G2_FB_MASK};

    logic [REG_W-1:0] gq [2];
    logic [1:0]       ones;
    logic             wrap;
    tap_pair_t        taps;

    for (genvar i = 0; i < 2; i++) begin : g_reg
        gr_lfsr #(.W(REG_W), .MASK(MASKS[i])) u_lfsr (
            .clk      (clk),
            .rst_n    (rst_n),
            .adv      (chip_en),
            .q        (gq[i]),
            .nxt_ones (ones[i])
        );
    end

    always_comb begin
        taps        = g2_taps(sv_sel);
        code_prompt = gq[0][REG_W-1] ^ gq[1][taps.a] ^ gq[1][taps.b];
        wrap        = chip_en & (&ones);
    end

    // R4: both registers return to all ones together
    a_r4_joint_start: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> (&gq[0]) && (&gq[1]));

    phase_track u_track (
        .clk        (clk),
        .rst_n      (rst_n),
        .chip_en    (chip_en),
        .wrap       (wrap),
        .snap       (snap),
        .resync_req (resync_req),
        .epoch      (epoch),
        .data_clk   (data_clk),
        .dither_clk (dither_clk),
        .chip_phase (chip_phase),
        .data_phase (data_phase)
    );

    dither_mux u_dither (
        .clk         (clk),
        .rst_n       (rst_n),
        .prompt      (code_prompt),
        .dither_clk  (dither_clk),
        .dly_sel     (dly_sel),
        .code_dither (code_dither)
    );
endmodule

// File: tb/sim_gold_replica.sv
module sim_gold_replica;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       chip_en, snap, resync_req;
    logic [4:0] sv_sel, dly_sel;
    logic       code_prompt, code_dither, epoch, data_clk, dither_clk;
    logic [9:0] chip_phase;
    logic [4:0] data_phase;

    always #4 clk = ~clk;

    gold_replica u0 (
        .clk(clk), .rst_n(rst_n), .chip_en(chip_en), .sv_sel(sv_sel),
        .dly_sel(dly_sel), .snap(snap), .resync_req(resync_req),
        .code_prompt(code_prompt), .code_dither(code_dither), .epoch(epoch),
        .data_clk(data_clk), .dither_clk(dither_clk),
        .chip_phase(chip_phase), .data_phase(data_phase)
    );

    int  checks = 0;
    int  fails  = 0;
    bit  wd     = 0;

    bit [9:0] mg1, mg2;
    int  mchip, mdcnt, mdith, mclat, mdlat, ens;
    bit  mep, marm;
    bit  mh [20];

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int tap_of(int sv, bit second);
        int p [64] = '{2,6, 3,7, 4,8, 5,9, 1,9, 2,10, 1,8, 2,9, 3,10, 2,3,
                       3,4, 5,6, 6,7, 7,8, 8,9, 9,10, 1,4, 2,5, 3,6, 4,7,
                       5,8, 6,9, 1,3, 4,6, 5,7, 6,8, 7,9, 8,10, 1,6, 2,7,
                       3,8, 4,9};
        return p[2*sv + (second ? 1 : 0)];
    endfunction

    function automatic bit code_of(bit [9:0] a, bit [9:0] b, int sv);
        return a[9] ^ b[tap_of(sv, 0) - 1] ^ b[tap_of(sv, 1) - 1];
    endfunction

    function automatic int dly_of(int d);
        if (d < 1)  return 1;
        if (d > 19) return 19;
        return d;
    endfunction

    task automatic compare_all();
        bit pr, dl;
        pr = code_of(mg1, mg2, int'(sv_sel));
        dl = mh[dly_of(int'(dly_sel)) - 1];
        chk("R1 prompt", int'(code_prompt), int'(pr));
        chk("R4 epoch", int'(epoch), int'(mep));
        chk("R5 chip latch", int'(chip_phase), mclat);
        chk("R5 data latch", int'(data_phase), mdlat);
        chk("R6 data_clk", int'(data_clk), int'(mdcnt < 10));
        chk("R8 dither_clk", int'(dither_clk), int'(mdith < 3));
        chk("R10 R9 code_dither", int'(code_dither), (mdith < 3) ? int'(dl) : int'(pr));
    endtask

    task automatic step(bit ce, bit sn, bit rq);
        bit [9:0] n1, n2;
        bit       wr, pre;
        chip_en    = ce;
        snap       = sn;
        resync_req = rq;
        pre = code_of(mg1, mg2, int'(sv_sel));
        n1  = {mg1[8:0], mg1[2] ^ mg1[9]};
        n2  = {mg2[8:0], ^(mg2 & 10'b11_1010_0110)};
        wr  = ce && (&n1) && (&n2);
        @(posedge clk);
        for (int k = 19; k > 0; k--) mh[k] = mh[k-1];
        mh[0] = pre;
        if (sn) begin
            mclat = mchip;
            mdlat = mdcnt;
        end
        if (ce) ens++;
        if (wr) begin
            chk("R4 enables per period", ens, 1023);
            ens = 0;
        end
        if (wr)      mchip = 0;
        else if (ce) mchip++;
        mep = wr;
        if (marm && wr) begin
            mdcnt = 0;
            marm  = 0;
        end else begin
            if (wr) mdcnt = (mdcnt == 19) ? 0 : mdcnt + 1;
            if (rq) marm = 1;
        end
        if (wr) mdith = (mdith == 5) ? 0 : mdith + 1;
        if (ce) begin
            mg1 = n1;
            mg2 = n2;
        end
        @(negedge clk);
        compare_all();
    endtask

    task automatic do_reset();
        rst_n = 1'b0; chip_en = 0; snap = 0; resync_req = 0;
        mg1 = '1; mg2 = '1; mchip = 0; mdcnt = 0; mdith = 0;
        mclat = 0; mdlat = 0; ens = 0; mep = 0; marm = 0;
        foreach (mh[k]) mh[k] = 0;
        repeat (3) @(negedge clk);
        // R2: reset state
        chk("R2 prompt", int'(code_prompt), 1);
        chk("R2 epoch", int'(epoch), 0);
        chk("R2 data_clk", int'(data_clk), 1);
        chk("R2 dither_clk", int'(dither_clk), 1);
        chk("R2 latches", int'(chip_phase) + int'(data_phase), 0);
        chk("R2 history", int'(code_dither), 0);
        rst_n = 1'b1;
    endtask

    task automatic main_seq();
        bit [9:0] first;
        void'($urandom(32'd4711));
        sv_sel = 5'd0;
        dly_sel = 5'd1;
        do_reset();
        // R1: first ten chips of satellite 1
        first = '0;
        for (int k = 0; k < 10; k++) begin
            first[9-k] = code_prompt;
            step(1, 0, 0);
        end
        chk("R1 first chips", int'(first), 10'b11_0010_0000);
        // R3: holding without enables
        for (int k = 0; k < 30; k++) step(0, 0, 0);
        // R5 R7: snapshot and request on the wrapping edge
        while (mchip != 1022) step(1, 0, 0);
        step(1, 1, 1);
        chk("R5 snap at wrap", int'(chip_phase), 1022);
        while (mchip != 1022) step(1, 0, ($urandom % 50) == 0);
        step(1, 0, 1);
        // R7: request absorbed on the realignment edge
        chk("R7 realigned", int'(data_clk), 1);
        step(1, 1, 0);
        chk("R7 count zero", int'(data_phase), 0);
        // R9: delay extremes
        dly_sel = 5'd0;
        for (int k = 0; k < 40; k++) step(1, 0, 0);
        dly_sel = 5'd31;
        for (int k = 0; k < 40; k++) step($urandom % 2, 0, 0);
        // random run
        for (int i = 0; i < 60000; i++) begin
            if (i % 500 == 0)  dly_sel = 5'($urandom % 32);
            if (i % 7000 == 0) sv_sel  = 5'($urandom % 32);
            step(($urandom % 3) != 0, ($urandom % 40) == 0, ($urandom % 4000) == 0);
        end
    endtask

    initial begin
        fork
            main_seq();
            begin
                repeat (150000) @(posedge clk);
                wd = 1;
            end
        join_any
        if (wd) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=expired expected=done");
        end
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule